// File: doc/BRIEF.md
# NAND Flash Controller Register Front-End

This block is the software-visible face of a simple 8-bit NAND flash controller. A host reaches it through a small word-addressed register bus. Most accesses land in local registers: configuration, timing, interrupt control and the transfer counter. Writes to the command or address register, and any access to the data register, become a request for one cycle on the flash bus. That request goes to a separate timing engine over a valid/ready port.

A page transfer is driven by loading the transfer counter, forcing chip enable through the configuration register and setting the start bit. Each data cycle the timing engine completes then moves the counter one step toward zero. When the counter reaches zero the block raises a transfer-done flag. A second flag records each rising edge of the flash ready/busy line, sampled through a synchroniser. Both flags can be masked onto a single interrupt output.

The engine port follows valid/ready rules. `cyc_valid` rises once per request. While it is high and `cyc_ready` is low, `cyc_kind` and `cyc_wdata` hold steady. A request is complete in the cycle where both are high, and for a read the engine supplies `cyc_rdata` in that same cycle. The host bus is held off the whole time: `bus_ack` comes only after the handshake, so engine back-pressure reaches the host as a longer access. The host keeps `bus_req` and its address and data stable until it sees the one-cycle `bus_ack`, then drops the request.

Top module: `nand_reg_frontend`

## Requirements
- R1: After reset, the configuration, interrupt enable, raw flag, masked status, control and transfer-count registers read 0, `flash_ce_n` is 1 and `irq` is 0.
- R2: A write to word 2 (command) issues one engine request with `cyc_kind`=0 and the low data byte. A write to word 1 (address) issues one request with `cyc_kind`=1. Reading either word returns 0 and issues no request.
- R3: A write to word 0 (data) or its alias word 14 issues a request with `cyc_kind`=2 carrying the low byte. A read of either word issues a request with `cyc_kind`=3, `cyc_wdata`=0, and returns the engine byte zero-extended.
- R4: Word 5 (configuration) holds 6 read/write bits. Bit 5 set drives `flash_ce_n` low, and clearing it drives `flash_ce_n` high.
- R5: Word 12 (transfer count) loads and reads back the count. Once bit 0 of word 4 (control) starts a transfer, each completed data cycle decrements the count. At zero the transfer ends: control bit 0 reads 0 and raw flag bit 1 sets. Further data cycles leave the count at 0, and data cycles with no transfer running leave the count unchanged.
- R6: Any write to word 3 (stop) ends a running transfer, and later data cycles leave the count unchanged.
- R7: The ready/busy input goes through a two-flop synchroniser. Status word 6 bit 0 shows the synchronised level. A rising edge sets raw flag bit 0, and a falling edge does not.
- R8: Word 7 reads the raw flags ANDed with the enable register (word 8). Word 9 reads the raw flags. `irq` is high exactly when an enabled flag is set.
- R9: Writing ones to word 9 sets the matching flags. Writing ones to word 10 clears them.
- R10: Writing control bit 2 clears configuration, interrupt enable, both flags, the count and the running state. The timing register keeps its value.
- R11: Writing control bit 1 gives a one-cycle `ecc_clear` pulse, which is visible in the cycle `bus_ack` is high.
- R12: Word 11 (timing) is a 32-bit read/write register driven onto `timing_cfg`.
- R13: A request holds `cyc_kind` and `cyc_wdata` stable until `cyc_ready`, and `bus_ack` follows the handshake. It is never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Host access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access completion |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| cyc_valid | output | 1 | Flash cycle request to timing engine |
| cyc_ready | input | 1 | Engine accepts and completes the request |
| cyc_kind | output | 2 | 0 command latch, 1 address latch, 2 data write, 3 data read |
| cyc_wdata | output | 8 | Byte for the flash cycle |
| cyc_rdata | input | 8 | Byte read by the engine, valid at handshake |
| flash_rb | input | 1 | Flash ready/busy pin, asynchronous |
| flash_ce_n | output | 1 | Chip enable, active low |
| timing_cfg | output | 32 | Timing register contents for the engine |
| ecc_clear | output | 1 | One-cycle ECC accumulator clear |
| irq | output | 1 | OR of enabled interrupt flags |

## Verification
A wrong access state shows up at once on the engine port. It can appear as a missing or duplicated request, a kind or byte that changes while the engine stalls, or a `bus_ack` ahead of the handshake. The scoreboard and the acknowledge-timing check catch each of these on the access that causes it. A counter or run-state fault shows within a few cycles of the last data cycle, as a wrong read-back of the count, the control bit or the done flag. Flag faults reach `irq` and the masked status word in the cycle after the event.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  localparam int DW        = 32;
  localparam int BW        = 8;
  localparam int REG_IDX_W = 4;
  localparam int CFG_W     = 6;
  localparam int INT_W     = 2;

  localparam logic [REG_IDX_W-1:0] IX_DATA  = 4'd0;
  localparam logic [REG_IDX_W-1:0] IX_ADDR  = 4'd1;
  localparam logic [REG_IDX_W-1:0] IX_CMD   = 4'd2;
  localparam logic [REG_IDX_W-1:0] IX_STOP  = 4'd3;
  localparam logic [REG_IDX_W-1:0] IX_CTRL  = 4'd4;
  localparam logic [REG_IDX_W-1:0] IX_CFG   = 4'd5;
  localparam logic [REG_IDX_W-1:0] IX_STAT  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IX_ISTAT = 4'd7;
  localparam logic [REG_IDX_W-1:0] IX_IEN   = 4'd8;
  localparam logic [REG_IDX_W-1:0] IX_ISET  = 4'd9;
  localparam logic [REG_IDX_W-1:0] IX_ICLR  = 4'd10;
  localparam logic [REG_IDX_W-1:0] IX_TIM   = 4'd11;
  localparam logic [REG_IDX_W-1:0] IX_TC    = 4'd12;
  localparam logic [REG_IDX_W-1:0] IX_ECC   = 4'd13;
  localparam logic [REG_IDX_W-1:0] IX_DMAD  = 4'd14;

  localparam int CTL_START  = 0;
  localparam int CTL_ECCCLR = 1;
  localparam int CTL_SWRST  = 2;
  localparam int CFG_CE     = 5;
  localparam int INT_RDY    = 0;
  localparam int INT_TC     = 1;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DWR  = 2'd2,
    CYC_DRD  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/nrf_sync.sv
module nrf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nrf_access.sv
module nrf_access
  import nrf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [BW-1:0]        wbyte,
  input  logic [DW-1:0]        reg_rdata,
  output logic                 bus_ack,
  output logic [DW-1:0]        bus_rdata,
  output logic                 reg_wr,
  output logic                 cyc_valid,
  input  logic                 cyc_ready,
  output cyc_kind_e            cyc_kind,
  output logic [BW-1:0]        cyc_wdata,
  input  logic [BW-1:0]        cyc_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} st_e;
  st_e       st;
  logic      is_data, is_latch, go_flash;
  cyc_kind_e kind_n;

  always_comb begin
    is_data  = (idx == IX_DATA) || (idx == IX_DMAD);
    is_latch = bus_we && ((idx == IX_ADDR) || (idx == IX_CMD));
    go_flash = is_data || is_latch;
    if (is_data)            kind_n = bus_we ? CYC_DWR : CYC_DRD;
    else if (idx == IX_CMD) kind_n = CYC_CMD;
    else                    kind_n = CYC_ADDR;
  end

  assign reg_wr    = (st == S_IDLE) && bus_req && bus_we && !go_flash;
  assign cyc_valid = (st == S_WAIT);
  assign bus_ack   = (st == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cyc_kind  <= CYC_CMD;
      cyc_wdata <= '0;
      bus_rdata <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (bus_req) begin
          if (go_flash) begin
            st        <= S_WAIT;
            cyc_kind  <= kind_n;
            cyc_wdata <= bus_we ? wbyte : '0;
          end else begin
            bus_rdata <= bus_we ? '0 : reg_rdata;
            st        <= S_ACK;
          end
        end
        S_WAIT: if (cyc_ready) begin
          bus_rdata <= (cyc_kind == CYC_DRD) ? {{(DW-BW){1'b0}}, cyc_rdata} : '0;
          st        <= S_ACK;
        end
        S_ACK:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R13: request attributes stay put while the engine stalls
  p_hold_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_kind) && $stable(cyc_wdata));

  // R13: acknowledge lasts one cycle and is never followed by a live request
  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack && !cyc_valid);

  // R13: a flash request always ends in an acknowledge
  p_hs_then_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_ready |=> bus_ack);
endmodule

// File: rtl/nrf_xfer.sv
module nrf_xfer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             stop,
  input  logic             dcyc,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             done
);
  assign done = run && (cnt == '0) && !start && !stop && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      if (load)                            cnt <= load_val;
      else if (run && dcyc && cnt != '0)   cnt <= cnt - 1'b1;
      if (stop)       run <= 1'b0;
      else if (start) run <= 1'b1;
      else if (done)  run <= 1'b0;
    end
  end

  // R5: the counter never climbs except through a load
  p_no_climb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));

  // R5: a transfer at zero ends on the next edge
  p_end_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == '0 && !start |=> !run);

  // R6: after a stop nothing counts
  p_stop_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !run);
endmodule

// File: rtl/nrf_irq.sv
module nrf_irq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] evt,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] en,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] flags_n;

  always_comb begin
    flags_n = (flags & ~(clr_we ? mask : '0)) | evt | (set_we ? mask : '0);
    if (clr) flags_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;

  assign irq = |(flags & en);

  // R10: software reset empties the flags
  p_swrst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> flags == '0);

  // R7: the ready flag only rises from an edge event or a set write
  p_rdy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(evt[0]) || $past(set_we && mask[0]));

  // R9: a clear write without a new event drops the flag
  p_clr_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && mask[0] && !evt[0] && !set_we |=> !flags[0]);
endmodule

// File: rtl/nand_reg_frontend.sv
module nand_reg_frontend
  import nrf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic                 bus_ack,
  output logic [DW-1:0]        bus_rdata,
  output logic                 cyc_valid,
  input  logic                 cyc_ready,
  output logic [1:0]           cyc_kind,
  output logic [BW-1:0]        cyc_wdata,
  input  logic [BW-1:0]        cyc_rdata,
  input  logic                 flash_rb,
  output logic                 flash_ce_n,
  output logic [DW-1:0]        timing_cfg,
  output logic                 ecc_clear,
  output logic                 irq
);
  logic             reg_wr, wr_ctrl, sw_rst, start, stop, load, dcyc;
  logic [CFG_W-1:0] cfg;
  logic [INT_W-1:0] ien, flags, evt;
  logic [CNT_W-1:0] cnt;
  logic             run, done, rb_s, rb_d;
  logic [DW-1:0]    rmux;
  cyc_kind_e        kind_e;

  nrf_access u_acc (
    .clk, .rst_n, .bus_req, .bus_we,
    .idx(bus_addr), .wbyte(bus_wdata[BW-1:0]), .reg_rdata(rmux),
    .bus_ack, .bus_rdata, .reg_wr,
    .cyc_valid, .cyc_ready, .cyc_kind(kind_e), .cyc_wdata, .cyc_rdata
  );
  assign cyc_kind = kind_e;

  assign wr_ctrl = reg_wr && (bus_addr == IX_CTRL);
  assign sw_rst  = wr_ctrl && bus_wdata[CTL_SWRST];
  assign start   = wr_ctrl && bus_wdata[CTL_START] && !sw_rst;
  assign stop    = reg_wr && (bus_addr == IX_STOP);
  assign load    = reg_wr && (bus_addr == IX_TC);
  assign dcyc    = cyc_valid && cyc_ready && kind_e[1];

  nrf_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk, .rst_n, .clr(sw_rst), .load, .load_val(bus_wdata[CNT_W-1:0]),
    .start, .stop, .dcyc, .cnt, .run, .done
  );

  nrf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .d(flash_rb), .q(rb_s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rb_d <= 1'b0;
    else        rb_d <= rb_s;

  assign evt[INT_RDY] = rb_s && !rb_d;
  assign evt[INT_TC]  = done;

  nrf_irq #(.W(INT_W)) u_irq (
    .clk, .rst_n, .clr(sw_rst), .evt,
    .set_we(reg_wr && (bus_addr == IX_ISET)),
    .clr_we(reg_wr && (bus_addr == IX_ICLR)),
    .mask(bus_wdata[INT_W-1:0]), .en(ien), .flags, .irq
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      ien        <= '0;
      timing_cfg <= '0;
      ecc_clear  <= 1'b0;
    end else begin
      ecc_clear <= wr_ctrl && bus_wdata[CTL_ECCCLR];
      if (reg_wr && bus_addr == IX_TIM) timing_cfg <= bus_wdata;
      if (sw_rst) begin
        cfg <= '0;
        ien <= '0;
      end else begin
        if (reg_wr && bus_addr == IX_CFG) cfg <= bus_wdata[CFG_W-1:0];
        if (reg_wr && bus_addr == IX_IEN) ien <= bus_wdata[INT_W-1:0];
      end
    end
  end

  assign flash_ce_n = !cfg[CFG_CE];

  always_comb begin
    unique case (bus_addr)
      IX_CTRL:  rmux = DW'(run);
      IX_CFG:   rmux = DW'(cfg);
      IX_STAT:  rmux = DW'({1'b0, cyc_valid, rb_s});
      IX_ISTAT: rmux = DW'(flags & ien);
      IX_IEN:   rmux = DW'(ien);
      IX_ISET:  rmux = DW'(flags);
      IX_TIM:   rmux = timing_cfg;
      IX_TC:    rmux = DW'(cnt);
      default:  rmux = '0;
    endcase
  end

  // R11: the clear pulse is a single cycle
  p_ecc_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clear |=> !ecc_clear);

  // R4: a configuration write with bit 5 set forces chip enable low
  p_ce_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && bus_addr == IX_CFG && bus_wdata[CFG_CE] |=> !flash_ce_n);
endmodule

// File: tb/nand_reg_frontend_tb.sv
`timescale 1ns/1ps
module nand_reg_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        cyc_valid;
  logic        cyc_ready = 1'b0;
  logic [1:0]  cyc_kind;
  logic [7:0]  cyc_wdata;
  logic [7:0]  cyc_rdata = '0;
  logic        flash_rb = 1'b0;
  logic        flash_ce_n;
  logic [31:0] timing_cfg;
  logic        ecc_clear;
  logic        irq;

  always #5 clk = ~clk;

  nand_reg_frontend u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int cyc_n = 0, hs_cyc = -1, ack_cyc = 0;
  int eng_wait = 0, eng_delay = 0, eng_reads = 0, exp_reads = 0;
  bit finished = 0;
  logic ecc_seen;
  logic [9:0] exp_q[$];
  logic [31:0] r;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  function automatic logic [7:0] rd_val(int k);
    return 8'h5A + 8'(k * 17);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // timing engine model and scoreboard monitor
  always @(negedge clk) begin
    if (cyc_ready) cyc_ready = 1'b0;
    else if (cyc_valid) begin
      if (eng_wait >= eng_delay) begin
        logic [9:0] item;
        cyc_ready = 1'b1;
        if (cyc_kind == 2'd3) begin
          cyc_rdata = rd_val(eng_reads);
          eng_reads++;
        end
        hs_cyc = cyc_n;
        eng_wait = 0;
        eng_delay = (eng_delay + 1) % 3;
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 unexpected engine request: got %h expected none", {cyc_kind, cyc_wdata});
        end else begin
          item = exp_q.pop_front();
          check(cyc_kind[1] ? "R3 data cycle" : "R2 latch cycle", 32'({cyc_kind, cyc_wdata}), 32'(item));
        end
      end else eng_wait++;
    end
  end

  task automatic acc(input logic we, input logic [3:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ack);
    rd = bus_rdata; ecc_seen = ecc_clear; ack_cyc = cyc_n;
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] x;
    acc(1'b1, a, d, x);
  endtask

  task automatic rd_chk(string tag, input logic [3:0] a, input logic [31:0] expv);
    logic [31:0] x;
    acc(1'b0, a, 32'h0, x);
    check(tag, x, expv);
  endtask

  // flash access: push expected request, then verify acknowledge follows the handshake
  task automatic flash_wr(input logic [3:0] a, input logic [1:0] kind, input logic [31:0] d);
    exp_q.push_back({kind, d[7:0]});
    hs_cyc = -1;
    wr(a, d);
    check("R13 ack after handshake", 32'(hs_cyc >= 0 && ack_cyc > hs_cyc), 32'd1);
  endtask

  task automatic flash_rd(input logic [3:0] a);
    logic [31:0] x;
    exp_q.push_back({2'd3, 8'h00});
    hs_cyc = -1;
    acc(1'b0, a, 32'h0, x);
    check("R3 data read value", x, 32'(rd_val(exp_reads)));
    exp_reads++;
    check("R13 ack after handshake", 32'(hs_cyc >= 0 && ack_cyc > hs_cyc), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog expired: got hang expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 ce_n", 32'(flash_ce_n), 32'd1);
    check("R1 irq", 32'(irq), 32'd0);
    rd_chk("R1 cfg", 4'd5, 0);
    rd_chk("R1 ien", 4'd8, 0);
    rd_chk("R1 tc", 4'd12, 0);
    rd_chk("R1 istat", 4'd7, 0);
    rd_chk("R1 flags", 4'd9, 0);
    rd_chk("R1 ctrl", 4'd4, 0);

    // R12 timing register
    wr(4'd11, 32'hA5C3_1E07);
    rd_chk("R12 timing readback", 4'd11, 32'hA5C3_1E07);
    check("R12 timing port", timing_cfg, 32'hA5C3_1E07);

    // R2 latch cycles
    flash_wr(4'd2, 2'd0, 32'h0000_0190);
    flash_wr(4'd1, 2'd1, 32'h0001_233C);
    rd_chk("R2 cmd read zero", 4'd2, 0);
    rd_chk("R2 addr read zero", 4'd1, 0);

    // R3 data cycles and alias
    flash_wr(4'd0, 2'd2, 32'h7E);
    flash_rd(4'd0);
    flash_wr(4'd14, 2'd2, 32'hFF11);
    flash_rd(4'd14);

    // R4 configuration and chip enable
    wr(4'd5, 32'h3F);
    rd_chk("R4 cfg readback", 4'd5, 32'h3F);
    check("R4 ce forced low", 32'(flash_ce_n), 32'd0);
    wr(4'd5, 32'h1F);
    check("R4 ce released", 32'(flash_ce_n), 32'd1);
    rd_chk("R4 cfg readback 2", 4'd5, 32'h1F);

    // R5 transfer counter
    wr(4'd10, 32'h3);
    wr(4'd12, 32'h3);
    rd_chk("R5 tc load", 4'd12, 32'h3);
    flash_wr(4'd0, 2'd2, 32'h01);
    rd_chk("R5 no count without start", 4'd12, 32'h3);
    wr(4'd4, 32'h1);
    rd_chk("R5 running", 4'd4, 32'h1);
    for (int i = 0; i < 3; i++) flash_wr(4'd0, 2'd2, 32'(8'h20 + i));
    rd_chk("R5 tc at zero", 4'd12, 0);
    rd_chk("R5 run ended", 4'd4, 0);
    rd_chk("R5 done flag", 4'd9, 32'h2);
    flash_wr(4'd0, 2'd2, 32'h44);
    rd_chk("R5 tc stays zero", 4'd12, 0);

    // R6 stop
    wr(4'd10, 32'h3);
    wr(4'd12, 32'h5);
    wr(4'd4, 32'h1);
    flash_wr(4'd0, 2'd2, 32'h50);
    flash_wr(4'd0, 2'd2, 32'h51);
    wr(4'd3, 32'h0);
    flash_wr(4'd0, 2'd2, 32'h52);
    rd_chk("R6 tc frozen", 4'd12, 32'h3);
    rd_chk("R6 no done flag", 4'd9, 0);

    // R7 ready/busy edge
    flash_rb = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R7 status level", 4'd6, 32'h1);
    rd_chk("R7 rising sets flag", 4'd9, 32'h1);
    wr(4'd10, 32'h1);
    flash_rb = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R7 falling no flag", 4'd9, 0);
    rd_chk("R7 status low", 4'd6, 0);
    flash_rb = 1'b1;
    repeat (4) @(negedge clk);
    wr(4'd10, 32'h3);

    // R8 masking, R9 set/clear
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h3);
    rd_chk("R8 masked status none", 4'd7, 0);
    check("R8 irq masked", 32'(irq), 32'd0);
    wr(4'd8, 32'h2);
    rd_chk("R8 masked status", 4'd7, 32'h2);
    check("R8 irq raised", 32'(irq), 32'd1);
    rd_chk("R9 set both", 4'd9, 32'h3);
    wr(4'd10, 32'h2);
    rd_chk("R9 clear one", 4'd9, 32'h1);
    check("R8 irq dropped", 32'(irq), 32'd0);
    wr(4'd10, 32'h1);
    rd_chk("R9 clear other", 4'd9, 0);

    // R11 ECC clear pulse
    wr(4'd4, 32'h2);
    check("R11 ecc pulse at ack", 32'(ecc_seen), 32'd1);
    wr(4'd5, 32'h0);
    check("R11 no pulse otherwise", 32'(ecc_seen), 32'd0);
    check("R11 pulse ended", 32'(ecc_clear), 32'd0);

    // R10 software reset
    wr(4'd5, 32'h3F);
    wr(4'd8, 32'h3);
    wr(4'd9, 32'h3);
    wr(4'd12, 32'h9);
    wr(4'd4, 32'h1);
    wr(4'd4, 32'h4);
    rd_chk("R10 cfg cleared", 4'd5, 0);
    rd_chk("R10 ien cleared", 4'd8, 0);
    rd_chk("R10 flags cleared", 4'd9, 0);
    rd_chk("R10 tc cleared", 4'd12, 0);
    rd_chk("R10 run cleared", 4'd4, 0);
    rd_chk("R10 timing kept", 4'd11, 32'hA5C3_1E07);
    check("R10 ce released", 32'(flash_ce_n), 32'd1);
    check("R10 irq low", 32'(irq), 32'd0);

    check("R2 scoreboard drained", 32'(exp_q.size()), 0);
    report();
  end
endmodule